// File: doc/BRIEF.md
# Write-Combining Strand Store Buffer

This block queues the pending stores of one hardware strand on their way to the shared second-level cache. Stores never touch the local first-level data cache. Each store is a whole cache line: a line address, line-wide data and one enable bit per byte. The queue has two slots. The oldest slot, the head, is offered to the L2 request port as soon as it holds a store. The second slot, the held entry, is not offered while the head is outstanding. Later stores to the held entry's line merge into it, so several narrow writes leave as one request.

The L2 request port is valid/ready. The block raises `l2_req_valid` whenever the head is occupied. A transfer happens on a rising edge where `l2_req_valid` and `l2_req_ready` are both high. Until that edge, the address, data and byte enables on the port must not change. When the head is acknowledged, the held entry becomes the new head and is offered on the next cycle.

The store side has no ready signal. `st_full` tells the scheduler that the strand must not be issued. A store that is presented while the queue is full, and that cannot merge, is refused, and `st_rollback` is raised in the same cycle.

The load lookup port is combinational. The load gives a line address and the line read from the data cache. The block returns that line with any buffered bytes laid over it.

Top module: `strand_store_buffer`

## Requirements
- R1: After reset the queue is empty: `st_full`, `l2_req_valid` and `ld_hit` are 0.
- R2: A store presented while the queue is empty is offered on the L2 port from the next cycle, with its address, data and byte enables.
- R3: A store presented while only the head is occupied and unacknowledged goes into the held slot and is not offered. From the next cycle `st_full` is 1.
- R4: While the queue is full, a store whose line address equals the held entry's line merges into it. Its enabled bytes overwrite the held bytes, the enables are ORed, and `st_rollback` stays 0.
- R5: While the queue is full, a store to any other line raises `st_rollback` in the same cycle and is dropped. No later request contains it.
- R6: When the head is acknowledged while the held slot is occupied, the held entry, including all merged bytes, is offered from the next cycle and `st_full` drops.
- R7: Stores reach the L2 port in the order they were accepted.
- R8: While `l2_req_valid` is 1 and `l2_req_ready` is 0, the request stays valid and its address, data and byte enables do not change.
- R9: A load whose line address equals a valid slot raises `ld_hit`. Byte i of `ld_data` comes from the held entry if that entry matches and enables byte i. Otherwise it comes from the head if the head matches and enables byte i. Otherwise it is byte i of `ld_cache_data`. Byte i occupies bits [8i+7:8i].
- R10: A load whose line matches no valid slot gives `ld_hit` = 0 and `ld_data` equal to `ld_cache_data`.
- R11: A store to the head's line while only the head is occupied does not merge into the head, which is already offered. It takes the held slot as a separate request.
- R12: If an acknowledge and a store arrive in the same cycle with only the head occupied, the store becomes the new head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | LAW | Store line address |
| st_data | input | 8*NB | Store line data |
| st_be | input | NB | Store byte enables |
| st_full | output | 1 | Both slots occupied; the strand is not ready |
| st_rollback | output | 1 | Presented store refused; the strand must replay it |
| ld_addr | input | LAW | Load line address |
| ld_cache_data | input | 8*NB | Line read from the data cache |
| ld_hit | output | 1 | Load line matches a buffered entry |
| ld_data | output | 8*NB | Cache line with buffered bytes laid over it |
| l2_req_valid | output | 1 | Head store offered to L2 |
| l2_req_addr | output | LAW | Offered line address |
| l2_req_data | output | 8*NB | Offered line data |
| l2_req_be | output | NB | Offered byte enables |
| l2_req_ready | input | 1 | L2 accepts the offered store |

## Verification
The hardest state to reach is a full queue whose held entry has absorbed several merges while the head is stalled. A second case is the same state hit by an acknowledge in the same cycle as a store. Both need the L2 ready held low across several stores to one line, followed by an acknowledge timed against a further store. The bench first sweeps every pair of byte-enable patterns through a fixed sequence: fill, merge, refused store, drain. It then runs a long pseudo-random stream over a four-line address space with sparse acknowledges. A bench-side model of the two slots predicts every request and every forwarded load byte in every cycle.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_HEAD  = 2'd1,
    OCC_BOTH  = 2'd2
  } occ_t;
endpackage

// File: rtl/ssb_merge.sv
module ssb_merge #(
  parameter int NB = 8
) (
  input  logic [8*NB-1:0] base,
  input  logic [8*NB-1:0] over,
  input  logic [NB-1:0]   sel,
  output logic [8*NB-1:0] out
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign out[8*i +: 8] = sel[i] ? over[8*i +: 8] : base[8*i +: 8];
  end
endmodule

// File: rtl/ssb_slots.sv
module ssb_slots
  import ssb_pkg::*;
#(
  parameter int LAW = 28,
  parameter int NB  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [LAW-1:0]  st_addr,
  input  logic [8*NB-1:0] st_data,
  input  logic [NB-1:0]   st_be,
  output logic            st_full,
  output logic            st_rollback,
  input  logic            req_ready,
  output logic            head_v,
  output logic [LAW-1:0]  head_a,
  output logic [8*NB-1:0] head_d,
  output logic [NB-1:0]   head_b,
  output logic            held_v,
  output logic [LAW-1:0]  held_a,
  output logic [8*NB-1:0] held_d,
  output logic [NB-1:0]   held_b
);
  occ_t            occ;
  logic [LAW-1:0]  a0, a1;
  logic [8*NB-1:0] d0, d1;
  logic [NB-1:0]   b0, b1;
  logic            combine, pop;
  logic [8*NB-1:0] comb_d, held_d_nx;
  logic [NB-1:0]   held_b_nx;

  assign st_full     = (occ == OCC_BOTH);
  assign combine     = st_valid && st_full && (a1 == st_addr);
  assign st_rollback = st_valid && st_full && !combine;
  assign pop         = (occ != OCC_EMPTY) && req_ready;

  ssb_merge #(.NB(NB)) u_comb (
    .base(d1), .over(st_data), .sel(st_be), .out(comb_d)
  );

  assign held_d_nx = combine ? comb_d : d1;
  assign held_b_nx = combine ? (b1 | st_be) : b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= OCC_EMPTY;
      a0 <= '0; d0 <= '0; b0 <= '0;
      a1 <= '0; d1 <= '0; b1 <= '0;
    end else begin
      case (occ)
        OCC_EMPTY: if (st_valid) begin
          a0 <= st_addr; d0 <= st_data; b0 <= st_be;
          occ <= OCC_HEAD;
        end
        OCC_HEAD: begin
          if (pop) begin
            if (st_valid) begin
              a0 <= st_addr; d0 <= st_data; b0 <= st_be;
            end else begin
              occ <= OCC_EMPTY;
            end
          end else if (st_valid) begin
            a1 <= st_addr; d1 <= st_data; b1 <= st_be;
            occ <= OCC_BOTH;
          end
        end
        OCC_BOTH: begin
          if (pop) begin
            a0 <= a1; d0 <= held_d_nx; b0 <= held_b_nx;
            occ <= OCC_HEAD;
          end else if (combine) begin
            d1 <= held_d_nx; b1 <= held_b_nx;
          end
        end
        default: occ <= OCC_EMPTY;
      endcase
    end
  end

  assign head_v = (occ != OCC_EMPTY);
  assign head_a = a0;
  assign head_d = d0;
  assign head_b = b0;
  assign held_v = st_full;
  assign held_a = a1;
  assign held_d = d1;
  assign held_b = b1;
endmodule

// File: rtl/ssb_fwd.sv
module ssb_fwd #(
  parameter int LAW = 28,
  parameter int NB  = 8
) (
  input  logic [LAW-1:0]  ld_addr,
  input  logic [8*NB-1:0] cache_d,
  input  logic            head_v,
  input  logic [LAW-1:0]  head_a,
  input  logic [8*NB-1:0] head_d,
  input  logic [NB-1:0]   head_b,
  input  logic            held_v,
  input  logic [LAW-1:0]  held_a,
  input  logic [8*NB-1:0] held_d,
  input  logic [NB-1:0]   held_b,
  output logic            hit,
  output logic [8*NB-1:0] data
);
  logic            m0, m1;
  logic [8*NB-1:0] after_head;

  assign m0  = head_v && (head_a == ld_addr);
  assign m1  = held_v && (held_a == ld_addr);
  assign hit = m0 || m1;

  ssb_merge #(.NB(NB)) u_older (
    .base(cache_d), .over(head_d), .sel(m0 ? head_b : '0), .out(after_head)
  );
  ssb_merge #(.NB(NB)) u_newer (
    .base(after_head), .over(held_d), .sel(m1 ? held_b : '0), .out(data)
  );
endmodule

// File: rtl/strand_store_buffer.sv
module strand_store_buffer #(
  parameter int LAW = 28,
  parameter int NB  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [LAW-1:0]  st_addr,
  input  logic [8*NB-1:0] st_data,
  input  logic [NB-1:0]   st_be,
  output logic            st_full,
  output logic            st_rollback,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [8*NB-1:0] ld_cache_data,
  output logic            ld_hit,
  output logic [8*NB-1:0] ld_data,
  output logic            l2_req_valid,
  output logic [LAW-1:0]  l2_req_addr,
  output logic [8*NB-1:0] l2_req_data,
  output logic [NB-1:0]   l2_req_be,
  input  logic            l2_req_ready
);
  logic            hv, lv;
  logic [LAW-1:0]  ha, la;
  logic [8*NB-1:0] hd, ldd;
  logic [NB-1:0]   hb, lb;

  ssb_slots #(.LAW(LAW), .NB(NB)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_full(st_full), .st_rollback(st_rollback),
    .req_ready(l2_req_ready),
    .head_v(hv), .head_a(ha), .head_d(hd), .head_b(hb),
    .held_v(lv), .held_a(la), .held_d(ldd), .held_b(lb)
  );

  ssb_fwd #(.LAW(LAW), .NB(NB)) u_fwd (
    .ld_addr(ld_addr), .cache_d(ld_cache_data),
    .head_v(hv), .head_a(ha), .head_d(hd), .head_b(hb),
    .held_v(lv), .held_a(la), .held_d(ldd), .held_b(lb),
    .hit(ld_hit), .data(ld_data)
  );

  assign l2_req_valid = hv;
  assign l2_req_addr  = ha;
  assign l2_req_data  = hd;
  assign l2_req_be    = hb;
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int LAW = 28,
  parameter int NB  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            st_valid,
  input logic [LAW-1:0]  st_addr,
  input logic [NB-1:0]   st_be,
  input logic            st_full,
  input logic            st_rollback,
  input logic            l2_req_valid,
  input logic [LAW-1:0]  l2_req_addr,
  input logic [8*NB-1:0] l2_req_data,
  input logic [NB-1:0]   l2_req_be,
  input logic            l2_req_ready
);
  a_r2_empty_store_offered: assert property (@(posedge clk) disable iff (!rst_n)
    (!l2_req_valid && st_valid) |=>
      (l2_req_valid && l2_req_addr == $past(st_addr) && l2_req_be == $past(st_be)));

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req_valid && !l2_req_ready) |=>
      (l2_req_valid && $stable(l2_req_addr) && $stable(l2_req_data) && $stable(l2_req_be)));

  a_r5_rollback_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    st_rollback |-> (st_full && st_valid));

  a_r3_full_implies_request: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> l2_req_valid);

  a_r6_ack_promotes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && l2_req_ready) |=> (l2_req_valid && !st_full));
endmodule

bind strand_store_buffer ssb_checker #(.LAW(LAW), .NB(NB)) u_ssb_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be),
  .st_full(st_full), .st_rollback(st_rollback), .l2_req_valid(l2_req_valid),
  .l2_req_addr(l2_req_addr), .l2_req_data(l2_req_data), .l2_req_be(l2_req_be),
  .l2_req_ready(l2_req_ready)
);

// File: tb/strand_store_buffer_tb.sv
`timescale 1ns/1ps
module strand_store_buffer_tb;
  localparam int LAW = 2;
  localparam int NB  = 4;
  localparam int DW  = 8*NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [LAW-1:0] st_addr = '0;
  logic [DW-1:0]  st_data = '0;
  logic [NB-1:0]  st_be = '0;
  logic st_full, st_rollback;
  logic [LAW-1:0] ld_addr = '0;
  logic [DW-1:0]  ld_cache_data = '0;
  logic ld_hit;
  logic [DW-1:0]  ld_data;
  logic l2_req_valid;
  logic [LAW-1:0] l2_req_addr;
  logic [DW-1:0]  l2_req_data;
  logic [NB-1:0]  l2_req_be;
  logic l2_req_ready = 1'b0;

  always #5 clk = ~clk;

  strand_store_buffer #(.LAW(LAW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_full(st_full), .st_rollback(st_rollback),
    .ld_addr(ld_addr), .ld_cache_data(ld_cache_data), .ld_hit(ld_hit), .ld_data(ld_data),
    .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr), .l2_req_data(l2_req_data),
    .l2_req_be(l2_req_be), .l2_req_ready(l2_req_ready)
  );

  int checks = 0;
  int fails = 0;

  // reference model: slot 0 is the head, slot 1 the held entry
  logic mv0 = 0, mv1 = 0;
  logic [LAW-1:0] ma0 = '0, ma1 = '0;
  logic [DW-1:0]  md0 = '0, md1 = '0;
  logic [NB-1:0]  mb0 = '0, mb1 = '0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] base, input logic [DW-1:0] over,
                                            input logic [NB-1:0] sel);
    logic [DW-1:0] r;
    r = base;
    for (int i = 0; i < NB; i++) if (sel[i]) r[8*i +: 8] = over[8*i +: 8];
    return r;
  endfunction

  task automatic step(input logic sv, input logic [LAW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [NB-1:0] sb, input logic ak, input logic [LAW-1:0] la,
                      input logic [DW-1:0] cd);
    logic full_e, rb_e, hit_e, merge, pop;
    logic [DW-1:0] ld_e, n1d;
    logic [NB-1:0] n1b;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    l2_req_ready = ak; ld_addr = la; ld_cache_data = cd;
    #1;
    full_e = mv0 && mv1;
    rb_e   = sv && full_e && (ma1 != sa);
    chk(st_full == full_e, "R3 full flag", 64'(st_full), 64'(full_e));
    chk(st_rollback == rb_e, "R5 rollback", 64'(st_rollback), 64'(rb_e));
    chk(l2_req_valid == mv0, "R2 R6 R12 request valid", 64'(l2_req_valid), 64'(mv0));
    if (mv0)
      chk({l2_req_addr, l2_req_be, l2_req_data} == {ma0, mb0, md0},
          "R4 R6 R7 R8 R11 request contents",
          64'({l2_req_addr, l2_req_be, l2_req_data}), 64'({ma0, mb0, md0}));
    hit_e = (mv0 && ma0 == la) || (mv1 && ma1 == la);
    ld_e = cd;
    if (mv0 && ma0 == la) ld_e = overlay(ld_e, md0, mb0);
    if (mv1 && ma1 == la) ld_e = overlay(ld_e, md1, mb1);
    if (hit_e)
      chk(ld_hit && ld_data == ld_e, "R9 load forward", 64'({ld_hit, ld_data}), 64'({1'b1, ld_e}));
    else
      chk(!ld_hit && ld_data == cd, "R10 load miss", 64'({ld_hit, ld_data}), 64'({1'b0, cd}));
    @(posedge clk);
    merge = sv && full_e && (ma1 == sa);
    pop   = mv0 && ak;
    n1d = merge ? overlay(md1, sd, sb) : md1;
    n1b = merge ? (mb1 | sb) : mb1;
    if (!mv0) begin
      if (sv) begin mv0 = 1; ma0 = sa; md0 = sd; mb0 = sb; end
    end else if (!mv1) begin
      if (pop) begin
        if (sv) begin ma0 = sa; md0 = sd; mb0 = sb; end
        else mv0 = 0;
      end else if (sv) begin
        mv1 = 1; ma1 = sa; md1 = sd; mb1 = sb;
      end
    end else begin
      if (pop) begin ma0 = ma1; md0 = n1d; mb0 = n1b; mv1 = 0; end
      else if (merge) begin md1 = n1d; mb1 = n1b; end
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    chk(!st_full && !l2_req_valid && !ld_hit, "R1 reset state",
        64'({st_full, l2_req_valid, ld_hit}), 64'd0);
    // sweep of every byte-enable pair: fill, same-line allocate, merge, refuse, drain
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        logic [DW-1:0] base;
        base = {8'(p), 8'(q), 8'(p + q), 8'(p ^ q)};
        step(1, 2'(p), base, 4'(p), 0, 2'(p), ~base);               // R2 enters empty queue
        step(1, 2'(p), base + 32'h0101_0101, 4'(q), 0, 2'(p), base); // R11 same line, new slot
        step(1, 2'(p), ~base, 4'(p ^ q), 0, 2'(p), 32'h0);           // R4 merge into held
        step(1, 2'(p + 1), base, 4'hF, 0, 2'(p + 1), base);          // R5 refused store
        step(1, 2'(p), base ^ 32'h5A5A_5A5A, 4'(q), 1, 2'(p), base); // R4 merge with ack, R6
        step(1, 2'(q), base, 4'(q), 1, 2'(q), base);                 // R12 ack plus store
        step(0, '0, '0, '0, 1, 2'(q), base);
        step(0, '0, '0, '0, 1, 2'(p), base);
      end
    end
    // long pseudo-random run with sparse acknowledges
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r1, r2, r3;
      seed = nxt(seed); r1 = seed;
      seed = nxt(seed); r2 = seed;
      seed = nxt(seed); r3 = seed;
      step(r1[31:30] != 2'b00, r1[5:4], r2, r1[11:8], r1[20:19] == 2'b11, r1[25:24], r3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule